// File: doc/BRIEF.md
# Serial EEPROM Word Master

This block drives a three-wire serial EEPROM (chip select, serial clock, data towards the device, data back from the device) as a bit-serial master. A host gives one start strobe together with an operation select, an address, a write word and an address length. The block then produces the serial waveform itself and reports the result with a one-cycle done pulse.

A read sends a single 32-bit frame and collects a 16-bit word. When the address length in use is longer than the device's real address width, the device answers with its dummy zero bit before the frame's address field is used up. The block notices this, shortens the frame so the data bits follow at once, and reports the width it found. A first read with a generous length therefore tells the host the device's real width.

A write is a guarded sequence of three frames: enable writes, the write itself, then disable writes. Each frame is followed by a programmed completion wait. All timing is counted in system clock cycles: a settle interval for every line phase and a longer wait after each write frame.

Top module: `mw_eeprom_master`

## Requirements
- R1: After reset, chip select, serial clock and serial data out are low, busy and done are low, the read word is 0 and the reported length equals DEF_ALEN.
- R2: A start seen while busy is low is taken on that clock edge. From the next cycle busy is high and the lines show chip select high, clock high, data low for SETTLE_CYC cycles.
- R3: Frame bits are sent from bit 31 down to bit 0. Each bit first shows clock low with the bit on the data line for SETTLE_CYC cycles, then clock high with the same data for SETTLE_CYC cycles. The clock is never high while chip select is low.
- R4: Frame encodings, with L the address length: read = ((0b110 << L) | address) << 16; write = (((0b101 << L) | address) << 16) | write word; enable = 0b10011 << (L-2); disable = 0b10000 << (L-2).
- R5: In a read, the device data line is sampled in the last cycle of every clock-high phase. The read word is the last 16 samples, the earliest of them in bit 15.
- R6: In a read, if a sample at frame bit i > 16 is zero, the reported length becomes L - (i - 16) and the next bit sent is bit 15. With no such sample, the reported length is L.
- R7: After the last frame the lines are all low for SETTLE_CYC cycles. Then done is high for exactly one cycle, with busy already low in that cycle.
- R8: A write sends the enable, write and disable frames in that order. After the last bit of each, chip select and clock stay high and data holds bit 0 for WAIT_CYC cycles, then all lines are low for SETTLE_CYC cycles. The next frame then starts as in R2.
- R9: A start while busy is high has no effect on the running transaction, and no transaction follows from it.
- R10: A write leaves the read word unchanged and reports the length it was given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (taken when not busy) |
| op_wr | input | 1 | 1 = write sequence, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Word to write |
| alen_cfg | input | ALEN_W | Address length to use |
| rdata | output | 16 | Last word read |
| alen_det | output | ALEN_W | Address length found by the last transaction |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ee_cs | output | 1 | Serial chip select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data towards the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
The bench builds the block with SETTLE_CYC = 2 and WAIT_CYC = 20, in place of the microsecond and millisecond defaults. At these values a whole three-frame write and every line phase fit in a few hundred cycles, so each cycle of each phase can be compared against the model. The device model has a 6-bit address, so reads with lengths 8 and 7 exercise the early-dummy-zero shortening at two different frame bits. Reads with length 6 exercise the path without shortening.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_LO,
    ST_HI,
    ST_HOLD,
    ST_DESEL
  } mw_state_t;

  typedef enum logic [1:0] {
    FR_READ,
    FR_WREN,
    FR_WRITE,
    FR_WRDIS
  } mw_frame_t;

  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam logic [2:0] OPC_WRITE = 3'b101;
  localparam logic [4:0] OPC_WREN  = 5'b10011;
  localparam logic [4:0] OPC_WRDIS = 5'b10000;

endpackage

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/mw_frame_gen.sv
module mw_frame_gen import mw_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int ALEN_W  = 4,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 32
) (
  input  mw_frame_t            kind,
  input  logic [ALEN_W-1:0]    alen,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [FRAME_W-1:0]   frame
);

  logic [FRAME_W-1:0] addr_ext;
  logic [ALEN_W-1:0]  guard_sh;

  assign addr_ext = FRAME_W'(addr);
  assign guard_sh = alen - ALEN_W'(2);

  // R4: opcode sits just above the address; guard commands are short frames
  always_comb begin
    case (kind)
      FR_READ:  frame = ((FRAME_W'(OPC_READ) << alen) | addr_ext) << DATA_W;
      FR_WRITE: frame = (((FRAME_W'(OPC_WRITE) << alen) | addr_ext) << DATA_W)
                        | FRAME_W'(wdata);
      FR_WREN:  frame = FRAME_W'(OPC_WREN) << guard_sh;
      default:  frame = FRAME_W'(OPC_WRDIS) << guard_sh;
    endcase
  end

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master import mw_pkg::*; #(
  parameter int ADDR_W     = 8,
  parameter int ALEN_W     = 4,
  parameter int DEF_ALEN   = 8,
  parameter int SETTLE_CYC = 200,
  parameter int WAIT_CYC   = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [ALEN_W-1:0] alen_cfg,
  output logic [15:0]       rdata,
  output logic [ALEN_W-1:0] alen_det,
  output logic              busy,
  output logic              done,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int DATA_W  = 16;
  localparam int FRAME_W = 32;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int MAX_CYC = (WAIT_CYC > SETTLE_CYC) ? WAIT_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LD   = CNT_W'(WAIT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_DMSB  = IDX_W'(DATA_W - 1);

  mw_state_t          state, nxt_state;
  mw_frame_t          kind, nxt_kind;
  logic [IDX_W-1:0]   bit_idx, nxt_idx;
  logic [ADDR_W-1:0]  lat_addr;
  logic [DATA_W-1:0]  lat_wdata;
  logic [ALEN_W-1:0]  lat_alen;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   ld_val;
  logic               tmr_exp, step, det_hit;
  logic               nxt_cs, nxt_sk, nxt_di;

  mw_frame_gen #(
    .ADDR_W(ADDR_W), .ALEN_W(ALEN_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)
  ) i_frame (
    .kind(kind), .alen(lat_alen), .addr(lat_addr), .wdata(lat_wdata), .frame(frame)
  );

  assign step = (state == ST_IDLE) ? start : tmr_exp;

  mw_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .load(step), .load_val(ld_val), .expired(tmr_exp)
  );

  // next-step decision, applied when the current phase has run out
  always_comb begin
    nxt_state = state;
    nxt_kind  = kind;
    nxt_idx   = bit_idx;
    ld_val    = SETTLE_LD;
    det_hit   = 1'b0;
    case (state)
      ST_IDLE: begin
        nxt_state = ST_SEL;
        nxt_kind  = op_wr ? FR_WREN : FR_READ;
      end
      ST_SEL: begin
        nxt_state = ST_LO;
        nxt_idx   = IDX_TOP;
      end
      ST_LO: nxt_state = ST_HI;
      ST_HI: begin
        if (kind == FR_READ && !ee_do && bit_idx > IDX_DATA) begin
          det_hit   = 1'b1;
          nxt_state = ST_LO;
          nxt_idx   = IDX_DMSB;
        end else if (bit_idx == '0) begin
          if (kind == FR_READ) begin
            nxt_state = ST_DESEL;
          end else begin
            nxt_state = ST_HOLD;
            ld_val    = WAIT_LD;
          end
        end else begin
          nxt_state = ST_LO;
          nxt_idx   = bit_idx - 1'b1;
        end
      end
      ST_HOLD: nxt_state = ST_DESEL;
      ST_DESEL: begin
        case (kind)
          FR_WREN:  begin nxt_kind = FR_WRITE; nxt_state = ST_SEL; end
          FR_WRITE: begin nxt_kind = FR_WRDIS; nxt_state = ST_SEL; end
          default:  nxt_state = ST_IDLE;
        endcase
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_comb begin
    nxt_cs = (nxt_state == ST_SEL) || (nxt_state == ST_LO) ||
             (nxt_state == ST_HI)  || (nxt_state == ST_HOLD);
    nxt_sk = (nxt_state == ST_SEL) || (nxt_state == ST_HI) || (nxt_state == ST_HOLD);
    case (nxt_state)
      ST_LO:          nxt_di = frame[nxt_idx];
      ST_HI, ST_HOLD: nxt_di = ee_di;
      default:        nxt_di = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= FR_READ;
      bit_idx   <= '0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_alen  <= ALEN_W'(DEF_ALEN);
      rdata     <= '0;
      alen_det  <= ALEN_W'(DEF_ALEN);
      busy      <= 1'b0;
      done      <= 1'b0;
      ee_cs     <= 1'b0;
      ee_sk     <= 1'b0;
      ee_di     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (step) begin
        state   <= nxt_state;
        kind    <= nxt_kind;
        bit_idx <= nxt_idx;
        ee_cs   <= nxt_cs;
        ee_sk   <= nxt_sk;
        ee_di   <= nxt_di;
        if (state == ST_IDLE) begin
          lat_addr  <= addr;
          lat_wdata <= wdata;
          lat_alen  <= alen_cfg;
          alen_det  <= alen_cfg;
          busy      <= 1'b1;
        end
        if (state == ST_HI && kind == FR_READ)
          rdata <= {rdata[DATA_W-2:0], ee_do};
        if (det_hit)
          alen_det <= lat_alen - ALEN_W'(bit_idx - IDX_DATA);
        if (state == ST_DESEL && nxt_state == ST_IDLE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> ee_cs); // R3

  AST_DI_STEADY_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ee_sk && ee_cs && $past(ee_sk) && $past(ee_cs)) |-> $stable(ee_di)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !ee_cs)); // R7

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ee_cs && !ee_sk && !ee_di)); // R1

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && ee_cs && ee_sk)); // R2

endmodule

// File: tb/test_mw_eeprom_master.sv
module test_mw_eeprom_master;

  localparam int S  = 2;
  localparam int W  = 20;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  alen_cfg = 4'd8;
  logic [15:0] rdata;
  logic [3:0]  alen_det;
  logic        busy, done, ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b1;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  mw_eeprom_master #(
    .ADDR_W(8), .ALEN_W(4), .DEF_ALEN(8), .SETTLE_CYC(S), .WAIT_CYC(W)
  ) i_mw_eeprom_master (
    .clk(clk), .rst(rst), .start(start), .op_wr(op_wr), .addr(addr),
    .wdata(wdata), .alen_cfg(alen_cfg), .rdata(rdata), .alen_det(alen_det),
    .busy(busy), .done(done), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  // behavioural serial EEPROM with a 6-bit address
  logic [15:0] mem [64];
  bit          wr_en = 1'b0;
  int          st = 0, nb = 0, dn = 0, ra = 0;
  logic [15:0] sh = '0;
  logic        prev_sk = 1'b0;

  always @(posedge clk) begin
    #2;
    if (!ee_cs) begin
      st = 0;
      ee_do = 1'b1;
    end else if (ee_sk && !prev_sk) begin
      case (st)
        0: if (ee_di) begin st = 1; nb = 0; sh = '0; end
        1: begin
          sh = {sh[14:0], ee_di};
          nb++;
          if (nb == AW + 2) begin
            ra = int'(sh[AW-1:0]);
            case (sh[AW+1:AW])
              2'b10: begin dn = 15; ee_do = 1'b0; st = 2; end
              2'b01: begin nb = 0; st = 3; end
              default: begin
                if (sh[AW-1:AW-2] == 2'b11) wr_en = 1'b1;
                else if (sh[AW-1:AW-2] == 2'b00) wr_en = 1'b0;
                st = 4;
              end
            endcase
          end
        end
        2: if (dn >= 0) begin ee_do = mem[ra][dn]; dn--; end else ee_do = 1'b1;
        3: begin
          sh = {sh[14:0], ee_di};
          nb++;
          if (nb == 16) begin
            if (wr_en) mem[ra] = sh;
            st = 4;
          end
        end
        default: ;
      endcase
    end
    prev_sk = ee_sk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one phase of the reference waveform, compared every cycle
  task automatic ph(input logic c, input logic s, input logic d, input int n,
                    input string req, output logic smp);
    smp = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp = ee_do;
      chk({ee_cs, ee_sk, ee_di, busy, done} == {c, s, d, 1'b1, 1'b0}, req,
          {27'd0, ee_cs, ee_sk, ee_di, busy, done}, {27'd0, c, s, d, 1'b1, 1'b0});
      @(posedge clk);
    end
  endtask

  // R4 encodings: 0 read, 1 enable, 2 write, 3 disable
  function automatic logic [31:0] frame_of(input int k, input logic [7:0] ad,
                                           input logic [15:0] dat, input int al);
    case (k)
      0:       return ((32'd6 << al) | {24'd0, ad}) << 16;
      1:       return 32'h13 << (al - 2);
      2:       return (((32'd5 << al) | {24'd0, ad}) << 16) | {16'd0, dat};
      default: return 32'h10 << (al - 2);
    endcase
  endfunction

  task automatic run(input bit wr, input logic [7:0] ad, input logic [15:0] dat,
                     input int al, output logic [15:0] rd, output logic [3:0] alo);
    logic [31:0] fr;
    logic [15:0] rdm;
    logic        v;
    int          cur_al;
    rdm = '0;
    cur_al = al;
    @(negedge clk);
    start = 1'b1; op_wr = wr; addr = ad; wdata = dat; alen_cfg = 4'(al);
    @(posedge clk);
    #1 start = 1'b0;
    for (int f = 0; f < (wr ? 3 : 1); f++) begin
      fr = frame_of(wr ? f + 1 : 0, ad, dat, al);
      ph(1'b1, 1'b1, 1'b0, S, "R2", v);
      begin
        int i = 31;
        while (i >= 0) begin
          ph(1'b1, 1'b0, fr[i], S, "R3", v);
          ph(1'b1, 1'b1, fr[i], S, "R3", v);
          if (!wr) begin
            rdm = {rdm[14:0], v};
            if (!v && i > 16) begin
              cur_al = cur_al - (i - 16);
              i = 15;
              continue;
            end
          end
          i--;
        end
      end
      if (wr) ph(1'b1, 1'b1, fr[0], W, "R8", v);
      ph(1'b0, 1'b0, 1'b0, S, "R7", v);
    end
    @(negedge clk);
    chk(done && !busy && !ee_cs, "R7", {29'd0, done, busy, ee_cs}, 32'h4);
    rd = rdata;
    alo = alen_det;
    if (!wr) chk(rdata == rdm, "R5", {16'd0, rdata}, {16'd0, rdm});
    chk(alen_det == 4'(cur_al), "R6", {28'd0, alen_det}, cur_al);
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] rd, last_rd;
    logic [3:0]  alo;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 40503 + 12345);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, busy, done} == 5'b0, "R1", {27'd0, ee_cs, ee_sk, ee_di, busy, done}, 0);
    chk(rdata == 16'd0 && alen_det == 4'd8, "R1", {12'd0, rdata, alen_det}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    chk({ee_cs, ee_sk, busy} == 3'b0, "R1", {29'd0, ee_cs, ee_sk, busy}, 0);

    // R6: length 8 against a 6-bit device, dummy zero at bit 18
    run(1'b0, 8'h2C, 16'h0, 8, rd, alo);
    chk(rd == mem[8'h2C >> 2], "R6", {16'd0, rd}, {16'd0, mem[8'h2C >> 2]});
    chk(alo == 4'd6, "R6", {28'd0, alo}, 6);

    // R6: length 7, dummy zero at bit 17
    run(1'b0, 8'h55, 16'h0, 7, rd, alo);
    chk(rd == mem[8'h55 >> 1], "R6", {16'd0, rd}, {16'd0, mem[8'h55 >> 1]});
    chk(alo == 4'd6, "R6", {28'd0, alo}, 6);

    // R4 / R5: exact length, no shortening, boundary addresses
    run(1'b0, 8'h21, 16'h0, 6, rd, alo);
    chk(rd == mem[8'h21], "R4", {16'd0, rd}, {16'd0, mem[8'h21]});
    run(1'b0, 8'h00, 16'h0, 6, rd, alo);
    chk(rd == mem[0], "R5", {16'd0, rd}, {16'd0, mem[0]});
    run(1'b0, 8'h3F, 16'h0, 6, rd, alo);
    chk(rd == mem[63], "R5", {16'd0, rd}, {16'd0, mem[63]});
    last_rd = rd;

    // R8 / R10: guarded write, then read back
    run(1'b1, 8'h05, 16'hA5C3, 6, rd, alo);
    chk(rd == last_rd, "R10", {16'd0, rd}, {16'd0, last_rd});
    chk(alo == 4'd6, "R10", {28'd0, alo}, 6);
    chk(mem[5] == 16'hA5C3, "R8", {16'd0, mem[5]}, 32'hA5C3);
    chk(!wr_en, "R8", {31'd0, wr_en}, 0);
    run(1'b0, 8'h05, 16'h0, 6, rd, alo);
    chk(rd == 16'hA5C3, "R8", {16'd0, rd}, 32'hA5C3);
    run(1'b1, 8'h3F, 16'h0F0F, 6, rd, alo);
    chk(mem[63] == 16'h0F0F && !wr_en, "R8", {16'd0, mem[63]}, 32'h0F0F);

    // R9: start pulsed mid-transaction is ignored
    fork
      run(1'b0, 8'h09, 16'h0, 6, rd, alo);
      begin
        repeat (12) @(negedge clk);
        start = 1'b1; op_wr = 1'b1; addr = 8'h11; wdata = 16'hDEAD; alen_cfg = 4'd6;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(rd == mem[9], "R9", {16'd0, rd}, {16'd0, mem[9]});
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!busy && !ee_cs, "R9", {30'd0, busy, ee_cs}, 0);
    end
    chk(mem[8'h11] != 16'hDEAD, "R9", {16'd0, mem[8'h11]}, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule